// File: doc/BRIEF.md
# Inter-Processor and Timer Interrupt Controller

This block holds the inter-processor interrupt (IPI) and periodic timer interrupt state for a four-processor system. It keeps one pending bit per processor for IPIs and one per processor for the timer. Each bit drives that processor's interrupt line directly. IPI lines are meant for the processor's level-3 interrupt input and timer lines for its level-2 input. Device interrupts (level 1) are handled elsewhere.

Software talks to the block through a 64-bit register port with a word address. A combined control register carries three per-processor command masks in one write: post IPI, clear IPI and clear timer. It also carries an acknowledge bit that is accepted and otherwise ignored. Separate registers post IPIs, clear IPIs and clear timer interrupts by a plain mask in bits [3:0]. Reads return the pending vectors, or the number of the processor making the read.

An external tick pulse raises the timer interrupt for every processor. The block reports redundant IPI posts and clears of non-pending IPIs as a warning pulse. Malformed or unsupported writes raise an error pulse.

Top module: `ipi_timer_ctrl`

## Requirements
- R1: While `rst_n` is low, and after it is released, both pending vectors and every interrupt line are zero, `warn_pulse` and `err_pulse` are low and `rdata` is zero.
- R2: A write to address 0 posts IPIs to the processors whose bits are set in wdata[15:12], where bit 12 is processor 0. A line that was already pending stays set and raises `warn_pulse`. IPI lines change only on writes.
- R3: A write to address 0 clears the IPIs of the processors set in wdata[11:8]. The clear is applied after the post of the same write. Clearing a processor with no pending IPI, after that post, raises `warn_pulse` and changes nothing.
- R4: A write to address 0 clears the timer interrupt of the processors set in wdata[7:4]. A processor whose timer interrupt is not pending is unaffected and no warning is raised. Timer lines rise only on a tick.
- R5: A write to address 0 whose only non-zero command field is wdata[28] is accepted: no error, no warning, no state change.
- R6: A write to address 0 with wdata[15:4] zero and wdata[28] zero raises `err_pulse` and changes no state.
- R7: A write to address 3 posts IPIs by the mask in wdata[3:0]. A write to address 1 clears IPIs by that mask. A write to address 2 clears timer interrupts by that mask. The same warning rules as R2 to R4 apply. A zero mask raises `err_pulse` and changes no state.
- R8: A `tick` sets the timer pending bit of every processor. Bits already pending stay set. A tick in the same cycle as a timer clear leaves all timer bits set.
- R9: With `rd_en` high, `rdata` is loaded at the next clock edge. Address 0 returns `req_cpu` in bits [1:0]. Address 1 returns the IPI pending vector in bits [3:0]. Address 2 returns the timer pending vector in bits [3:0]. All other bits are zero. A read and a write in the same cycle return the state from before the write. Without `rd_en`, `rdata` holds its value.
- R10: A write to any address above 3 raises `err_pulse` and changes no state. A read of such an address returns zero.
- R11: `warn_pulse` and `err_pulse` are high for exactly the one cycle after the edge that accepted the causing write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Register word address |
| wdata | input | 64 | Write data |
| req_cpu | input | 2 | Number of the processor issuing the access |
| tick | input | 1 | Timer tick pulse |
| rdata | output | 64 | Registered read data |
| ipi_irq | output | 4 | Per-processor IPI interrupt lines |
| tmr_irq | output | 4 | Per-processor timer interrupt lines |
| warn_pulse | output | 1 | Redundant post or empty clear seen |
| err_pulse | output | 1 | Unsupported or malformed write seen |

## Verification
Every result is due one clock after its stimulus. A write or tick presented before edge N changes the interrupt lines, the warning and the error pulse right after edge N. A read presented before edge N has its data on `rdata` from edge N onward. The bench drives inputs shortly after a rising edge and compares against its model at the falling edge, so every comparison lands half a cycle after the edge that made the result. Directed checks sample just after the following rising edge, when the previous operation's effects have all settled.

// File: rtl/ipt_pkg.sv
`timescale 1ns/1ps
package ipt_pkg;
    localparam int NCPU    = 4;
    localparam int CPUID_W = $clog2(NCPU);
    localparam int ADDR_W  = 4;

    typedef logic [NCPU-1:0] cpu_mask_t;

    // register word addresses
    localparam logic [ADDR_W-1:0] A_CTRL     = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_IPI_STAT = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_TMR_STAT = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] A_IPI_POST = ADDR_W'(3);

    // field positions of the combined control register
    localparam int CTRL_TCLR_LSB = 4;
    localparam int CTRL_ICLR_LSB = CTRL_TCLR_LSB + NCPU;
    localparam int CTRL_POST_LSB = CTRL_ICLR_LSB + NCPU;
    localparam int CTRL_ACK_BIT  = 28;

    typedef struct packed {
        cpu_mask_t ipi_post;
        cpu_mask_t ipi_clr;
        cpu_mask_t tmr_clr;
        logic      bad;
    } wr_cmd_t;
endpackage

// File: rtl/ipt_wr_decode.sv
`timescale 1ns/1ps
module ipt_wr_decode
    import ipt_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output wr_cmd_t           cmd
);
    localparam int FIELD_HI = CTRL_POST_LSB + NCPU;

    cpu_mask_t f_post, f_iclr, f_tclr, f_mask;
    logic      f_ack;
    logic      unused_wdata;

    assign f_post = wdata[CTRL_POST_LSB +: NCPU];
    assign f_iclr = wdata[CTRL_ICLR_LSB +: NCPU];
    assign f_tclr = wdata[CTRL_TCLR_LSB +: NCPU];
    assign f_mask = wdata[NCPU-1:0];
    assign f_ack  = wdata[CTRL_ACK_BIT];
    assign unused_wdata = ^{wdata[DATA_W-1:CTRL_ACK_BIT+1],
                            wdata[CTRL_ACK_BIT-1:FIELD_HI]};

    always_comb begin
        cmd = '0;
        if (wr_en) begin
            unique case (addr)
                A_CTRL: begin
                    cmd.ipi_post = f_post;
                    cmd.ipi_clr  = f_iclr;
                    cmd.tmr_clr  = f_tclr;
                    cmd.bad      = (f_post == '0) && (f_iclr == '0) &&
                                   (f_tclr == '0) && !f_ack;
                end
                A_IPI_STAT: begin
                    cmd.ipi_clr = f_mask;
                    cmd.bad     = (f_mask == '0);
                end
                A_TMR_STAT: begin
                    cmd.tmr_clr = f_mask;
                    cmd.bad     = (f_mask == '0);
                end
                A_IPI_POST: begin
                    cmd.ipi_post = f_mask;
                    cmd.bad      = (f_mask == '0);
                end
                default: cmd.bad = 1'b1;
            endcase
            if (cmd.bad) begin
                cmd.ipi_post = '0;
                cmd.ipi_clr  = '0;
                cmd.tmr_clr  = '0;
            end
        end
    end
endmodule

// File: rtl/ipt_ipi_bank.sv
`timescale 1ns/1ps
module ipt_ipi_bank
    import ipt_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  cpu_mask_t post,
    input  cpu_mask_t clr,
    output cpu_mask_t pend,
    output logic      warn
);
    typedef struct packed {
        cpu_mask_t pend;
    } ipi_st_t;

    ipi_st_t   st_d, st_q;
    cpu_mask_t after_post;

    always_comb begin
        after_post = st_q.pend | post;
        st_d.pend  = after_post & ~clr;
        // redundant post, or clear of a bit still idle after the post
        warn = |(post & st_q.pend) | |(clr & ~after_post);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend = st_q.pend;
endmodule

// File: rtl/ipt_tmr_bank.sv
`timescale 1ns/1ps
module ipt_tmr_bank
    import ipt_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  cpu_mask_t clr,
    output cpu_mask_t pend
);
    typedef struct packed {
        cpu_mask_t pend;
    } tmr_st_t;

    tmr_st_t st_d, st_q;

    always_comb begin
        st_d.pend = st_q.pend & ~clr;
        for (int c = 0; c < NCPU; c++) begin
            if (tick) st_d.pend[c] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend = st_q.pend;
endmodule

// File: rtl/ipt_rd_mux.sv
`timescale 1ns/1ps
module ipt_rd_mux
    import ipt_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic [CPUID_W-1:0] req_cpu,
    input  cpu_mask_t          ipi_pend,
    input  cpu_mask_t          tmr_pend,
    output logic [DATA_W-1:0]  data
);
    always_comb begin
        unique case (addr)
            A_CTRL:     data = DATA_W'(req_cpu);
            A_IPI_STAT: data = DATA_W'(ipi_pend);
            A_TMR_STAT: data = DATA_W'(tmr_pend);
            default:    data = '0;
        endcase
    end
endmodule

// File: rtl/ipi_timer_ctrl.sv
`timescale 1ns/1ps
module ipi_timer_ctrl
    import ipt_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [CPUID_W-1:0] req_cpu,
    input  logic               tick,
    output logic [DATA_W-1:0]  rdata,
    output logic [NCPU-1:0]    ipi_irq,
    output logic [NCPU-1:0]    tmr_irq,
    output logic               warn_pulse,
    output logic               err_pulse
);
    typedef struct packed {
        logic [DATA_W-1:0] rdata;
        logic              warn;
        logic              err;
    } top_st_t;

    wr_cmd_t           cmd;
    cpu_mask_t         ipi_pend, tmr_pend;
    logic              ipi_warn;
    logic [DATA_W-1:0] rd_word;
    top_st_t           st_d, st_q;

    ipt_wr_decode #(.DATA_W(DATA_W)) u_dec (
        .wr_en (wr_en),
        .addr  (addr),
        .wdata (wdata),
        .cmd   (cmd)
    );

    ipt_ipi_bank u_ipi (
        .clk   (clk),
        .rst_n (rst_n),
        .post  (cmd.ipi_post),
        .clr   (cmd.ipi_clr),
        .pend  (ipi_pend),
        .warn  (ipi_warn)
    );

    ipt_tmr_bank u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .clr   (cmd.tmr_clr),
        .pend  (tmr_pend)
    );

    ipt_rd_mux #(.DATA_W(DATA_W)) u_rd (
        .addr     (addr),
        .req_cpu  (req_cpu),
        .ipi_pend (ipi_pend),
        .tmr_pend (tmr_pend),
        .data     (rd_word)
    );

    always_comb begin
        st_d       = st_q;
        st_d.warn  = ipi_warn;
        st_d.err   = cmd.bad;
        if (rd_en) st_d.rdata = rd_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata      = st_q.rdata;
    assign warn_pulse = st_q.warn;
    assign err_pulse  = st_q.err;
    assign ipi_irq    = ipi_pend;
    assign tmr_irq    = tmr_pend;
endmodule

// File: rtl/ipi_timer_ctrl_sva.sv
`timescale 1ns/1ps
module ipi_timer_ctrl_sva
    import ipt_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic               rd_en,
    input logic [ADDR_W-1:0]  addr,
    input logic [DATA_W-1:0]  wdata,
    input logic [CPUID_W-1:0] req_cpu,
    input logic               tick,
    input logic [DATA_W-1:0]  rdata,
    input logic [NCPU-1:0]    ipi_irq,
    input logic [NCPU-1:0]    tmr_irq,
    input logic               warn_pulse,
    input logic               err_pulse
);
    p_ipi_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ipi_irq));

    p_tmr_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ((tmr_irq & ~$past(tmr_irq)) == '0));

    p_ctrl_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_CTRL && wdata[15:4] == '0 && !wdata[CTRL_ACK_BIT] && !tick)
        |=> (err_pulse && $stable(ipi_irq) && $stable(tmr_irq)));

    p_post_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_IPI_POST)
        |=> ((ipi_irq & $past(wdata[NCPU-1:0])) == $past(wdata[NCPU-1:0])));

    p_tick_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (&tmr_irq));

    p_cpu_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == A_CTRL) |=> (rdata == DATA_W'($past(req_cpu))));

    p_rd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));

    p_bad_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr > A_IPI_POST) |=> (err_pulse && $stable(ipi_irq)));

    p_pulse_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (warn_pulse || err_pulse) |-> $past(wr_en));
endmodule

bind ipi_timer_ctrl ipi_timer_ctrl_sva #(.DATA_W(DATA_W)) u_sva (.*);

// File: tb/ipi_timer_ctrl_bench.sv
`timescale 1ns/1ps
module ipi_timer_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0, tick = 1'b0;
    logic [3:0]  addr = '0;
    logic [63:0] wdata = '0;
    logic [1:0]  req_cpu = '0;
    logic [63:0] rdata;
    logic [3:0]  ipi_irq, tmr_irq;
    logic        warn_pulse, err_pulse;

    int    n_cmp = 0, n_bad = 0;
    bit    done = 0;
    string cur_tag = "R1";

    // reference model state
    logic [3:0]  m_ipi = '0, m_tmr = '0;
    logic        m_warn = 0, m_err = 0;
    logic [63:0] m_rdata = '0;

    always #4 clk = ~clk;

    ipi_timer_ctrl u_ipi_timer_ctrl (
        .clk, .rst_n, .wr_en, .rd_en, .addr, .wdata, .req_cpu, .tick,
        .rdata, .ipi_irq, .tmr_irq, .warn_pulse, .err_pulse
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // behavioural model, updated on each rising edge
    always @(posedge clk) begin
        logic [3:0] p, ic, tc;
        if (!rst_n) begin
            m_ipi = '0; m_tmr = '0; m_warn = 0; m_err = 0; m_rdata = '0;
        end else begin
            p = '0; ic = '0; tc = '0; m_warn = 0; m_err = 0;
            if (rd_en) begin
                if (addr == 0)      m_rdata = {62'd0, req_cpu};
                else if (addr == 1) m_rdata = {60'd0, m_ipi};
                else if (addr == 2) m_rdata = {60'd0, m_tmr};
                else                m_rdata = '0;
            end
            if (wr_en) begin
                if (addr == 0) begin
                    if (wdata[15:4] == 0 && !wdata[28]) m_err = 1;
                    else begin p = wdata[15:12]; ic = wdata[11:8]; tc = wdata[7:4]; end
                end else if (addr >= 1 && addr <= 3) begin
                    if (wdata[3:0] == 0) m_err = 1;
                    else if (addr == 1) ic = wdata[3:0];
                    else if (addr == 2) tc = wdata[3:0];
                    else                p  = wdata[3:0];
                end else m_err = 1;
            end
            for (int c = 0; c < 4; c++)
                if (p[c]) begin if (m_ipi[c]) m_warn = 1; else m_ipi[c] = 1; end
            for (int c = 0; c < 4; c++)
                if (ic[c]) begin if (m_ipi[c]) m_ipi[c] = 0; else m_warn = 1; end
            for (int c = 0; c < 4; c++)
                if (tc[c]) m_tmr[c] = 0;
            if (tick) m_tmr = 4'hF;
        end
    end

    // per-clock comparison, half a cycle after the edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk({cur_tag, " ipi_irq"},    {60'd0, ipi_irq},    {60'd0, m_ipi});
            chk({cur_tag, " tmr_irq"},    {60'd0, tmr_irq},    {60'd0, m_tmr});
            chk({cur_tag, " warn_pulse"}, {63'd0, warn_pulse}, {63'd0, m_warn});
            chk({cur_tag, " err_pulse"},  {63'd0, err_pulse},  {63'd0, m_err});
            chk({cur_tag, " rdata"},      rdata,               m_rdata);
        end
    end

    task automatic op(input string tag, input logic w, input logic [3:0] a,
                      input logic [63:0] d, input logic r, input logic tk,
                      input logic [1:0] cpu);
        @(posedge clk); #2;
        cur_tag = tag;
        wr_en = w; addr = a; wdata = d; rd_en = r; tick = tk; req_cpu = cpu;
    endtask

    task automatic idle();
        @(posedge clk); #2;
        wr_en = 0; rd_en = 0; tick = 0; wdata = '0; addr = '0;
    endtask

    task automatic wr(input string tag, input logic [3:0] a, input logic [63:0] d);
        op(tag, 1, a, d, 0, 0, 2'd0);
        idle();
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL R1 watchdog: actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1;
        @(posedge clk); #2;
        chk("R1 ipi after reset", {60'd0, ipi_irq}, 0);
        chk("R1 tmr after reset", {60'd0, tmr_irq}, 0);
        chk("R1 rdata after reset", rdata, 0);
        chk("R1 pulses after reset", {62'd0, warn_pulse, err_pulse}, 0);

        op("R9 read cpu id", 0, 4'd0, 0, 1, 0, 2'd2); idle();
        chk("R9 cpu id 2", rdata, 64'd2);
        op("R9 read cpu id", 0, 4'd0, 0, 1, 0, 2'd1); idle();
        chk("R9 cpu id 1", rdata, 64'd1);

        wr("R2 ctrl post", 4'd0, 64'h5000);
        chk("R2 post 0 and 2", {60'd0, ipi_irq}, 64'h5);
        chk("R2 no warn", {63'd0, warn_pulse}, 0);
        wr("R2 redundant post", 4'd0, 64'h3000);
        chk("R2 post adds 1", {60'd0, ipi_irq}, 64'h7);
        chk("R2 redundant warn", {63'd0, warn_pulse}, 1);
        idle();
        chk("R11 warn one cycle", {63'd0, warn_pulse}, 0);

        wr("R3 ctrl clear", 4'd0, 64'h0200);
        chk("R3 clear 1", {60'd0, ipi_irq}, 64'h5);
        wr("R3 empty clear", 4'd0, 64'h0800);
        chk("R3 empty clear warn", {63'd0, warn_pulse}, 1);
        chk("R3 empty clear state", {60'd0, ipi_irq}, 64'h5);
        wr("R3 post then clear", 4'd0, 64'h8800);
        chk("R3 post-then-clear state", {60'd0, ipi_irq}, 64'h5);
        chk("R3 post-then-clear no warn", {63'd0, warn_pulse}, 0);

        wr("R6 empty ctrl", 4'd0, 64'h0);
        chk("R6 error", {63'd0, err_pulse}, 1);
        wr("R6 low bits only", 4'd0, 64'hF);
        chk("R6 error low bits", {63'd0, err_pulse}, 1);
        chk("R6 state kept", {60'd0, ipi_irq}, 64'h5);
        wr("R5 ack only", 4'd0, 64'h1000_0000);
        chk("R5 no error", {63'd0, err_pulse}, 0);
        chk("R5 state kept", {60'd0, ipi_irq}, 64'h5);

        op("R8 tick", 0, 4'd0, 0, 0, 1, 2'd0); idle();
        chk("R8 tick sets all", {60'd0, tmr_irq}, 64'hF);
        op("R8 second tick", 0, 4'd0, 0, 0, 1, 2'd0); idle();
        chk("R8 second tick", {60'd0, tmr_irq}, 64'hF);

        wr("R4 timer clear", 4'd0, 64'h0030);
        chk("R4 clear 0 and 1", {60'd0, tmr_irq}, 64'hC);
        wr("R4 timer clear idle", 4'd0, 64'h0030);
        chk("R4 no warn", {63'd0, warn_pulse}, 0);
        chk("R4 unchanged", {60'd0, tmr_irq}, 64'hC);
        op("R8 tick with clear", 1, 4'd0, 64'h00F0, 0, 1, 2'd0); idle();
        chk("R8 tick wins", {60'd0, tmr_irq}, 64'hF);

        wr("R7 timer status clear", 4'd2, 64'h5);
        chk("R7 timer clear mask", {60'd0, tmr_irq}, 64'hA);
        wr("R7 post register", 4'd3, 64'hA);
        chk("R7 post mask", {60'd0, ipi_irq}, 64'hF);
        wr("R7 ipi status clear", 4'd1, 64'h3);
        chk("R7 ipi clear mask", {60'd0, ipi_irq}, 64'hC);
        wr("R7 zero mask", 4'd1, 64'h0);
        chk("R7 zero mask error", {63'd0, err_pulse}, 1);
        wr("R7 upper bits only", 4'd3, 64'h30);
        chk("R7 upper bits error", {63'd0, err_pulse}, 1);
        chk("R7 state kept", {60'd0, ipi_irq}, 64'hC);
        wr("R7 clear idle", 4'd1, 64'h1);
        chk("R7 empty clear warn", {63'd0, warn_pulse}, 1);

        op("R9 read ipi", 0, 4'd1, 0, 1, 0, 2'd3); idle();
        chk("R9 ipi vector", rdata, 64'hC);
        op("R9 read tmr", 0, 4'd2, 0, 1, 0, 2'd3); idle();
        chk("R9 tmr vector", rdata, 64'hA);
        op("R9 read during write", 1, 4'd1, 64'h4, 1, 0, 2'd0); idle();
        chk("R9 old value read", rdata, 64'hC);
        chk("R9 write applied", {60'd0, ipi_irq}, 64'h8);
        idle();
        chk("R9 rdata holds", rdata, 64'hC);

        wr("R10 bad address", 4'd5, 64'hFFFF);
        chk("R10 error", {63'd0, err_pulse}, 1);
        chk("R10 state kept", {60'd0, ipi_irq}, 64'h8);
        op("R10 read bad", 0, 4'd7, 0, 1, 0, 2'd3); idle();
        chk("R10 read zero", rdata, 0);
        idle();
        chk("R11 err one cycle", {63'd0, err_pulse}, 0);

        idle();
        done = 1;
        summary();
        $finish;
    end
endmodule